// File: doc/BRIEF.md
# Read/Write Direction Selector

This block sits in front of a memory scheduler and decides, every clock cycle, whether the scheduler serves the read store or the write store. Each store reports only whether it currently holds work. One store is the preferred side and the other is the fallback. The preferred side is reads unless a configuration bit selects writes.

The selector stays on the preferred side while that side has work. When the preferred side runs dry, an idle counter starts. The block moves to the fallback side only after the preferred side has been idle for a programmed number of consecutive cycles and the fallback side has work. It comes back as soon as the preferred side has work again.

Both configuration inputs are captured only while reset is held, and they stay frozen once reset is released. The outputs are combinational from the registered state and the current pending flags, so a zero idle gap takes effect in the same cycle. There is no data path and no handshake. All pins are plain control and status signals.

Top module: `rw_dir_select`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dir_wr_o` shows the preferred direction and `switch_o` is 0. Encoding: `dir_wr_o` = 1 means writes, 0 means reads.
- R2: With `cfg_prefer_wr_i` = 1 at reset, writes are the preferred side and reads are the fallback. With it at 0, reads are preferred.
- R3: With idle gap G, suppose the preferred side is empty in G+1 consecutive cycles, and the fallback side has work in the last of them. Then the direction changes to the fallback side in that last cycle, and not earlier.
- R4: With G = 0, the direction changes to the fallback side in the very cycle the preferred side is empty while the fallback side has work.
- R5: Any cycle in which the preferred side has work restarts the idle count, so the consecutive-empty window begins again.
- R6: While on the fallback side, the direction returns to the preferred side in the same cycle that the preferred side has work.
- R7: When both sides are empty, the direction holds and `switch_o` is 0.
- R8: `switch_o` is 1 exactly in the cycles where `dir_wr_o` differs from its value in the previous cycle.
- R9: Changes to `cfg_prefer_wr_i` or `cfg_idle_gap_i` while reset is released have no effect on behaviour.
- R10: The idle count saturates at G. With the maximum G = 127, the switch still occurs after exactly 128 empty cycles. After a long run with both sides empty, work arriving on the fallback side switches at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| rd_pending_i | input | 1 | Read store holds at least one transaction |
| wr_pending_i | input | 1 | Write store holds at least one transaction |
| cfg_prefer_wr_i | input | 1 | 1 makes writes the preferred side |
| cfg_idle_gap_i | input | GAP_W (7) | Consecutive idle cycles of the preferred side before moving over |
| dir_wr_o | output | 1 | Served direction: 1 write, 0 read |
| switch_o | output | 1 | One-cycle pulse on every direction change |

## Verification
Several properties are checked on every cycle by the assertions. A pulse never appears while both sides are empty. Any pulse coincides with a real change of direction. A return is forced whenever the preferred side has work while the fallback side is served. A move to the fallback side needs that side to have work and the preferred side to be empty. The idle count never exceeds the frozen gap, and the frozen configuration never moves after reset.

The exact cycle of each switch can only be shown by the bench scenarios. These cover gaps of 0, 3 and 127, interrupted idle runs, the reversed preference, and configuration changes made after reset.

// File: rtl/rwsel_pkg.sv
package rwsel_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  // Physical direction from the preference and the "on fallback" state.
  function automatic dir_e to_dir(input logic prefer_wr, input logic on_alt);
    return dir_e'(prefer_wr ^ on_alt);
  endfunction
endpackage

// File: rtl/rwsel_cfg_hold.sv
module rwsel_cfg_hold #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prefer_wr_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             prefer_wr_o,
  output logic [GAP_W-1:0] gap_o
);
  logic             pref_q;
  logic [GAP_W-1:0] gap_q;

  // Track the pins only while held in reset; freeze afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pref_q <= prefer_wr_i;
      gap_q  <= gap_i;
    end
  end

  assign prefer_wr_o = pref_q;
  assign gap_o       = gap_q;

  // R9: frozen configuration
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(pref_q) && $stable(gap_q)));
endmodule

// File: rtl/rwsel_idle_timer.sv
module rwsel_idle_timer #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pref_busy_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             reached_o
);
  logic [GAP_W-1:0] run_q;
  logic [GAP_W-1:0] run_d;

  // run_q = preceding consecutive idle cycles of the preferred side, capped at gap.
  always_comb begin
    if (pref_busy_i)
      run_d = '0;
    else if (run_q >= gap_i)
      run_d = gap_i;
    else
      run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_q <= '0;
    else
      run_q <= run_d;
  end

  assign reached_o = (run_q >= gap_i);

  // R10: count never passes the threshold
  a_r10_run_capped: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= gap_i);
  // R5: activity on the preferred side restarts the window
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    pref_busy_i |=> (run_q == '0));
endmodule

// File: rtl/rwsel_dir_fsm.sv
module rwsel_dir_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic pref_busy_i,
  input  logic alt_busy_i,
  input  logic gap_reached_i,
  output logic on_alt_o,
  output logic switch_o
);
  logic on_alt_q;
  logic on_alt_d;

  always_comb begin
    if (!rst_n)
      on_alt_d = 1'b0;
    else if (on_alt_q)
      on_alt_d = !pref_busy_i;              // leave as soon as preferred has work
    else
      on_alt_d = !pref_busy_i && alt_busy_i && gap_reached_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      on_alt_q <= 1'b0;
    else
      on_alt_q <= on_alt_d;
  end

  assign on_alt_o = on_alt_d;
  assign switch_o = rst_n && (on_alt_d != on_alt_q);

  // R6: preferred work while on fallback forces an immediate return
  a_r6_prompt_return: assert property (@(posedge clk) disable iff (!rst_n)
    (on_alt_q && pref_busy_i) |-> (switch_o && !on_alt_o));
  // R7: nothing pending means no movement
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pref_busy_i && !alt_busy_i) |-> !switch_o);
endmodule

// File: rtl/rw_dir_select.sv
module rw_dir_select #(
  parameter int GAP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_pending_i,
  input  logic             wr_pending_i,
  input  logic             cfg_prefer_wr_i,
  input  logic [GAP_W-1:0] cfg_idle_gap_i,
  output logic             dir_wr_o,
  output logic             switch_o
);
  import rwsel_pkg::*;

  logic             pref_wr;
  logic [GAP_W-1:0] gap;
  logic             pref_busy;
  logic             alt_busy;
  logic             reached;
  logic             on_alt;
  dir_e             dir;

  rwsel_cfg_hold #(.GAP_W(GAP_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .prefer_wr_i (cfg_prefer_wr_i),
    .gap_i       (cfg_idle_gap_i),
    .prefer_wr_o (pref_wr),
    .gap_o       (gap)
  );

  // Map physical stores onto preferred / fallback roles.
  assign pref_busy = pref_wr ? wr_pending_i : rd_pending_i;
  assign alt_busy  = pref_wr ? rd_pending_i : wr_pending_i;

  rwsel_idle_timer #(.GAP_W(GAP_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .pref_busy_i (pref_busy),
    .gap_i       (gap),
    .reached_o   (reached)
  );

  rwsel_dir_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pref_busy_i   (pref_busy),
    .alt_busy_i    (alt_busy),
    .gap_reached_i (reached),
    .on_alt_o      (on_alt),
    .switch_o      (switch_o)
  );

  assign dir      = to_dir(pref_wr, on_alt);
  assign dir_wr_o = (dir == DIR_WR);

  // R8: a pulse always marks a real change of direction
  a_r8_pulse_is_change: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_o && $past(rst_n)) |-> (dir_wr_o != $past(dir_wr_o)));
  // R3: moving to the fallback side needs work there and none on the preferred side
  a_r3_move_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_o && (dir_wr_o != pref_wr)) |-> (alt_busy && !pref_busy));
endmodule

// File: tb/rw_dir_select_tb_top.sv
module rw_dir_select_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_p = 1'b0;
  logic       wr_p = 1'b0;
  logic       cfg_pw = 1'b0;
  logic [6:0] cfg_gap = 7'd0;
  logic       dir_wr;
  logic       sw;

  int total = 0;
  int bad = 0;

  bit    exp_dir_q[$];
  bit    exp_sw_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  rw_dir_select #(.GAP_W(7)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_pending_i    (rd_p),
    .wr_pending_i    (wr_p),
    .cfg_prefer_wr_i (cfg_pw),
    .cfg_idle_gap_i  (cfg_gap),
    .dir_wr_o        (dir_wr),
    .switch_o        (sw)
  );

  // Driver: apply inputs for one cycle and queue the expected outputs.
  task automatic step(input bit rd, input bit wr, input bit e_dir, input bit e_sw,
                      input string tag);
    @(negedge clk);
    rd_p = rd;
    wr_p = wr;
    exp_dir_q.push_back(e_dir);
    exp_sw_q.push_back(e_sw);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input bit pw, input logic [6:0] gap);
    @(negedge clk);
    rst_n   = 1'b0;
    cfg_pw  = pw;
    cfg_gap = gap;
    rd_p    = 1'b0;
    wr_p    = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    total++;
    if (dir_wr !== pw || sw !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: dir=%0b sw=%0b expected dir=%0b sw=0", dir_wr, sw, pw);
    end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compare outputs against the queue away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_dir_q.size() > 0) begin
        bit    ed;
        bit    es;
        string t;
        ed = exp_dir_q.pop_front();
        es = exp_sw_q.pop_front();
        t  = tag_q.pop_front();
        total++;
        if (dir_wr !== ed || sw !== es) begin
          bad++;
          $display("FAIL %s: dir=%0b sw=%0b expected dir=%0b sw=%0b", t, dir_wr, sw, ed, es);
        end
      end
    end
  end

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Reads preferred, gap 3
    do_reset(1'b0, 7'd3);
    step(1, 1, 0, 0, "R1 first cycle");
    step(0, 1, 0, 0, "R3 idle1");
    step(0, 1, 0, 0, "R3 idle2");
    step(0, 1, 0, 0, "R3 idle3");
    step(0, 1, 1, 1, "R3 switch on 4th");
    step(0, 1, 1, 0, "R8 stay no pulse");
    step(1, 1, 0, 1, "R6 return");
    // R5: interrupted idle run
    step(0, 1, 0, 0, "R5 idle1");
    step(0, 1, 0, 0, "R5 idle2");
    step(1, 1, 0, 0, "R5 busy restart");
    step(0, 1, 0, 0, "R5 idle1b");
    step(0, 1, 0, 0, "R5 idle2b");
    step(0, 1, 0, 0, "R5 idle3b");
    step(0, 1, 1, 1, "R5 switch after restart");
    // R7: both empty on fallback side
    step(0, 0, 1, 0, "R7 hold on fallback");
    step(0, 0, 1, 0, "R7 hold on fallback 2");
    step(1, 0, 0, 1, "R6 return from empty");
    // R7 / R10: long empty run on preferred side then fallback work
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, "R7 hold on preferred");
    step(0, 1, 1, 1, "R10 saturated switch");
    step(1, 0, 0, 1, "R6 return read");

    // Writes preferred, gap 0
    do_reset(1'b1, 7'd0);
    step(1, 1, 1, 0, "R2 write preferred");
    step(1, 0, 0, 1, "R4 immediate switch");
    step(1, 0, 0, 0, "R4 stay on read");
    step(1, 1, 1, 1, "R6 back to write");
    // R9: change config outside reset
    @(negedge clk);
    cfg_pw  = 1'b0;
    cfg_gap = 7'd100;
    step(1, 1, 1, 0, "R9 preference kept");
    step(1, 0, 0, 1, "R9 gap kept at zero");
    step(0, 0, 0, 0, "R7 both empty hold");
    step(0, 1, 1, 1, "R9 return to write");

    // Reads preferred, maximum gap
    do_reset(1'b0, 7'd127);
    step(1, 1, 0, 0, "R10 start");
    for (int i = 0; i < 127; i++) step(0, 1, 0, 0, "R10 waiting");
    step(0, 1, 1, 1, "R10 switch at 128");
    step(1, 1, 0, 1, "R6 return max gap");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule